// File: doc/BRIEF.md
# Secure Interrupt Class Router

This block sits between an interrupt controller's group assignment and a processor core's exception logic. For each pending interrupt it decides two things: whether the request is signalled to the core as a fast interrupt (FIQ) or a normal interrupt (IRQ), and which exception level the resulting exception targets. The FIQ/IRQ choice is not a priority level. It follows from the interrupt's group and from the security state of the code running at the time. The target level comes from three route-to-top control bits, one each for FIQ, IRQ and SError. A registered take-now / keep-pending flag combines the target level with the core's mask bits.

The processor side supplies the current exception level, the security state of levels 0 and 1, and its three mask bits. An interrupt routed above the current level ignores the current level's mask. An interrupt aimed at the current level obeys the mask. An interrupt aimed below the current level waits. Each exception taken sets a nesting block, which holds off further same-level takes until software clears a mask bit or the level changes. SError requests use their own path with their own route bit and mask bit.

Top module: `intr_class_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is 0 after that edge.
- R2: With `single_ss_i`=1, group codes 0 (group 0), 1 (secure group 1) and 3 (reserved, treated as group 0) give `int_kind_o`=2 (FIQ). Code 2 (non-secure group 1) gives `int_kind_o`=1 (IRQ).
- R3: With `single_ss_i`=0, group codes 0 and 3 always give FIQ (2), and every request that arrives while `cur_el_i`=3 gives FIQ.
- R4: With `single_ss_i`=0 and `cur_el_i`<3, the current state is secure when `ns_state_i`=0. A group 1 request (code 1 secure, code 2 non-secure) gives IRQ (1) when its security matches the current state, and FIQ (2) when it differs.
- R5: The target level is 3 when the route bit for the signalled type is 1 (`route_fiq_i` for FIQ, `route_irq_i` for IRQ). When that bit is 0, the target is 2 if `cur_el_i`=2 and 1 otherwise.
- R6: When the target level is above `cur_el_i`, the request is taken (`*_take_o`=1) whatever the mask bits and the nesting block.
- R7: When the target equals `cur_el_i`, the request is taken only if its mask bit is 0 and the nesting block is clear. The mask bits are `mask_i[0]` for FIQ, `mask_i[1]` for IRQ and `mask_i[2]` for SError.
- R8: When the target is below `cur_el_i`, the request is never taken and stays pending (`*_pend_o`=1).
- R9: SError uses the same rules with `route_serr_i` and `mask_i[2]`, and it does so independently of the interrupt path.
- R10: A take on either path sets the nesting block. Once set, it suppresses same-level takes. It clears in any cycle where some `mask_i` bit goes from 1 to 0, or where `cur_el_i` differs from its value in the previous cycle.
- R11: Every output reflects the inputs of the previous clock edge. A change of `ns_state_i` or `cur_el_i` alone re-classifies a still-pending request one cycle later, for example from FIQ to IRQ.
- R12: With no request on a path, that path's kind, target, take and pend outputs are 0. With a request, exactly one of take and pend is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_ss_i | input | 1 | Single-security-state mode (two groups only) |
| int_req_i | input | 1 | An interrupt is pending at the core interface |
| int_grp_i | input | 2 | Group code: 0 group 0, 1 secure group 1, 2 non-secure group 1, 3 reserved |
| serr_req_i | input | 1 | An SError is pending |
| ns_state_i | input | 1 | Levels 0 and 1 run non-secure when 1 |
| cur_el_i | input | 2 | Current exception level 0..3 |
| route_fiq_i | input | 1 | Route FIQ to level 3 |
| route_irq_i | input | 1 | Route IRQ to level 3 |
| route_serr_i | input | 1 | Route SError to level 3 |
| mask_i | input | 3 | Core mask bits: [0] FIQ, [1] IRQ, [2] SError |
| int_kind_o | output | 2 | 0 none, 1 IRQ, 2 FIQ |
| int_tgt_el_o | output | 2 | Target level of the interrupt |
| int_take_o | output | 1 | Interrupt exception taken now |
| int_pend_o | output | 1 | Interrupt kept pending |
| serr_tgt_el_o | output | 2 | Target level of the SError |
| serr_take_o | output | 1 | SError taken now |
| serr_pend_o | output | 1 | SError kept pending |

## Verification
A wrong classification state shows up at the ports one cycle after the inputs that exposed it, as a wrong `int_kind_o` or a wrong target level. The nesting block is the only state kept across cycles. If it is stuck set, same-level takes disappear. If it is stuck clear, `*_take_o` stays high for consecutive cycles where a single pulse is expected. Either fault is visible within two cycles of a same-level take. The bench runs a level-by-level model next to the design, so a divergence is reported in the cycle it occurs.

// File: rtl/icr_pkg.sv
// Shared encodings for the interrupt class router.
// Assumes a four-level exception model with level 3 as the top level.
package icr_pkg;
    localparam int EL_W     = 2;
    localparam int GRP_W    = 2;
    localparam int MASK_W   = 3;
    localparam int N_PATH   = 2;
    localparam int PATH_INT = 0;
    localparam int PATH_SER = 1;

    localparam logic [EL_W-1:0] EL_TOP  = 2'd3;
    localparam logic [EL_W-1:0] EL_HYP  = 2'd2;
    localparam logic [EL_W-1:0] EL_LOW1 = 2'd1;

    localparam logic [GRP_W-1:0] GRP_G0   = 2'd0;
    localparam logic [GRP_W-1:0] GRP_G1S  = 2'd1;
    localparam logic [GRP_W-1:0] GRP_G1NS = 2'd2;
    localparam logic [GRP_W-1:0] GRP_RSV  = 2'd3;

    localparam int MB_FIQ = 0;
    localparam int MB_IRQ = 1;
    localparam int MB_SER = 2;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_IRQ  = 2'd1,
        KIND_FIQ  = 2'd2
    } kind_e;
endpackage

// File: rtl/icr_class_sel.sv
// Chooses FIQ or IRQ for one interrupt from its group and the running state.
// Assumes: combinational only; request gating is done by the caller.
module icr_class_sel
    import icr_pkg::*;
(
    input  logic             single_ss,
    input  logic [GRP_W-1:0] grp,
    input  logic             ns_state,
    input  logic [EL_W-1:0]  cur_el,
    output kind_e            kind
);
    logic at_top;
    logic cur_secure;
    logic grp_is_g0;
    logic grp_secure;

    // Derive security facts about the running code and the group.
    always_comb begin
        at_top     = (cur_el == EL_TOP);
        cur_secure = at_top || !ns_state;
        grp_is_g0  = (grp == GRP_G0) || (grp == GRP_RSV);
        grp_secure = (grp != GRP_G1NS);
    end

    // Pick the signal type for the selected group mode.
    always_comb begin
        if (single_ss) begin
            kind = (grp == GRP_G1NS) ? KIND_IRQ : KIND_FIQ;
        end else if (grp_is_g0 || at_top) begin
            kind = KIND_FIQ;
        end else begin
            kind = (grp_secure == cur_secure) ? KIND_IRQ : KIND_FIQ;
        end
    end
endmodule

// File: rtl/icr_route_take.sv
// Resolves target level and take/pend for one exception path.
// Assumes the route and mask bits are already selected for the path's type.
module icr_route_take
    import icr_pkg::*;
(
    input  logic            req,
    input  logic            route_top,
    input  logic [EL_W-1:0] cur_el,
    input  logic            mask_bit,
    input  logic            blocked,
    output logic [EL_W-1:0] tgt_el,
    output logic            take,
    output logic            pend
);
    logic [EL_W-1:0] first_el;
    logic [EL_W-1:0] tgt_raw;
    logic            go_up;
    logic            same_lvl;

    // Compute the lowest level able to take the exception.
    always_comb begin
        first_el = (cur_el == EL_HYP) ? EL_HYP : EL_LOW1;
        tgt_raw  = route_top ? EL_TOP : first_el;
    end

    // Compare target against current level and apply masking.
    always_comb begin
        go_up    = (tgt_raw > cur_el);
        same_lvl = (tgt_raw == cur_el);
        take     = req && (go_up || (same_lvl && !mask_bit && !blocked));
        pend     = req && !take;
        tgt_el   = req ? tgt_raw : '0;
    end
endmodule

// File: rtl/icr_nest_guard.sv
// Holds the nesting block that follows any taken exception.
// Assumes a mask bit falling or a level change marks explicit re-enable.
module icr_nest_guard
    import icr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] mask,
    input  logic [EL_W-1:0]   cur_el,
    input  logic              take_any,
    output logic              blocked
);
    logic              blk_q;
    logic [MASK_W-1:0] mask_q;
    logic [EL_W-1:0]   el_q;
    logic              release_now;

    // Detect explicit unmasking or a level change this cycle.
    always_comb begin
        release_now = (|(mask_q & ~mask)) || (el_q != cur_el);
        blocked     = blk_q && !release_now;
    end

    // Track block state and previous-cycle mask and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= 1'b0;
            mask_q <= '0;
            el_q   <= '0;
        end else begin
            mask_q <= mask;
            el_q   <= cur_el;
            if (take_any)         blk_q <= 1'b1;
            else if (release_now) blk_q <= 1'b0;
        end
    end
endmodule

// File: rtl/intr_class_router.sv
// Top of the secure interrupt class router: classifies, routes and gates
// one interrupt and one SError per cycle, with registered outputs.
// Assumes inputs are synchronous to clk.
module intr_class_router
    import icr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_ss_i,
    input  logic              int_req_i,
    input  logic [GRP_W-1:0]  int_grp_i,
    input  logic              serr_req_i,
    input  logic              ns_state_i,
    input  logic [EL_W-1:0]   cur_el_i,
    input  logic              route_fiq_i,
    input  logic              route_irq_i,
    input  logic              route_serr_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic [1:0]        int_kind_o,
    output logic [EL_W-1:0]   int_tgt_el_o,
    output logic              int_take_o,
    output logic              int_pend_o,
    output logic [EL_W-1:0]   serr_tgt_el_o,
    output logic              serr_take_o,
    output logic              serr_pend_o
);
    kind_e           kind_c;
    logic            is_fiq;
    logic            blocked;
    logic [N_PATH-1:0] req_v;
    logic [N_PATH-1:0] route_v;
    logic [N_PATH-1:0] mbit_v;
    logic [N_PATH-1:0] take_v;
    logic [N_PATH-1:0] pend_v;
    logic [EL_W-1:0]   tgt_v [N_PATH];

    icr_class_sel u_cls (
        .single_ss (single_ss_i),
        .grp       (int_grp_i),
        .ns_state  (ns_state_i),
        .cur_el    (cur_el_i),
        .kind      (kind_c)
    );

    // Select per-path request, route and mask bits.
    always_comb begin
        is_fiq            = (kind_c == KIND_FIQ);
        req_v[PATH_INT]   = int_req_i;
        route_v[PATH_INT] = is_fiq ? route_fiq_i : route_irq_i;
        mbit_v[PATH_INT]  = is_fiq ? mask_i[MB_FIQ] : mask_i[MB_IRQ];
        req_v[PATH_SER]   = serr_req_i;
        route_v[PATH_SER] = route_serr_i;
        mbit_v[PATH_SER]  = mask_i[MB_SER];
    end

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        icr_route_take u_rt (
            .req       (req_v[p]),
            .route_top (route_v[p]),
            .cur_el    (cur_el_i),
            .mask_bit  (mbit_v[p]),
            .blocked   (blocked),
            .tgt_el    (tgt_v[p]),
            .take      (take_v[p]),
            .pend      (pend_v[p])
        );
    end

    icr_nest_guard u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask     (mask_i),
        .cur_el   (cur_el_i),
        .take_any (|take_v),
        .blocked  (blocked)
    );

    // Register all decisions for a one-cycle, glitch-free result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_kind_o    <= KIND_NONE;
            int_tgt_el_o  <= '0;
            int_take_o    <= 1'b0;
            int_pend_o    <= 1'b0;
            serr_tgt_el_o <= '0;
            serr_take_o   <= 1'b0;
            serr_pend_o   <= 1'b0;
        end else begin
            int_kind_o    <= int_req_i ? kind_c : KIND_NONE;
            int_tgt_el_o  <= tgt_v[PATH_INT];
            int_take_o    <= take_v[PATH_INT];
            int_pend_o    <= pend_v[PATH_INT];
            serr_tgt_el_o <= tgt_v[PATH_SER];
            serr_take_o   <= take_v[PATH_SER];
            serr_pend_o   <= pend_v[PATH_SER];
        end
    end
endmodule

// File: rtl/icr_chk.sv
// Port-level temporal checks for intr_class_router, attached by bind.
module icr_chk
    import icr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              single_ss_i,
    input logic              int_req_i,
    input logic              serr_req_i,
    input logic [EL_W-1:0]   cur_el_i,
    input logic              route_fiq_i,
    input logic              route_irq_i,
    input logic              route_serr_i,
    input logic [1:0]        int_kind_o,
    input logic              int_take_o,
    input logic              int_pend_o,
    input logic [EL_W-1:0]   serr_tgt_el_o,
    input logic              serr_take_o,
    input logic              serr_pend_o
);
    // R3: top-level arrivals in three-group mode are FIQ
    a_r3_top_fiq: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_ss_i && int_req_i && cur_el_i == EL_TOP) |=> int_kind_o == KIND_FIQ);

    // R6: routed upward from below the top is always taken
    a_r6_up_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req_i && route_fiq_i && route_irq_i && cur_el_i != EL_TOP) |=> int_take_o);

    // R8: at the top with low routing the request waits
    a_r8_wait_down: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req_i && cur_el_i == EL_TOP && !route_fiq_i && !route_irq_i)
        |=> (!int_take_o && int_pend_o));

    // R9: SError route bit selects the top level
    a_r9_serr_top: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_req_i && route_serr_i) |=> serr_tgt_el_o == EL_TOP);

    // R12: no request leaves the interrupt outputs idle
    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req_i |=> (int_kind_o == KIND_NONE && !int_take_o && !int_pend_o));

    // R12: take and pend never together
    a_r12_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_take_o && int_pend_o) && !(serr_take_o && serr_pend_o));
endmodule

bind intr_class_router icr_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .single_ss_i   (single_ss_i),
    .int_req_i     (int_req_i),
    .serr_req_i    (serr_req_i),
    .cur_el_i      (cur_el_i),
    .route_fiq_i   (route_fiq_i),
    .route_irq_i   (route_irq_i),
    .route_serr_i  (route_serr_i),
    .int_kind_o    (int_kind_o),
    .int_take_o    (int_take_o),
    .int_pend_o    (int_pend_o),
    .serr_tgt_el_o (serr_tgt_el_o),
    .serr_take_o   (serr_take_o),
    .serr_pend_o   (serr_pend_o)
);

// File: tb/tb_intr_class_router.sv
module tb_intr_class_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       single_ss_i = 1'b0, int_req_i = 1'b0, serr_req_i = 1'b0, ns_state_i = 1'b0;
    logic [1:0] int_grp_i = 2'd0, cur_el_i = 2'd0;
    logic       route_fiq_i = 1'b0, route_irq_i = 1'b0, route_serr_i = 1'b0;
    logic [2:0] mask_i = 3'd0;
    logic [1:0] int_kind_o, int_tgt_el_o, serr_tgt_el_o;
    logic       int_take_o, int_pend_o, serr_take_o, serr_pend_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // model state
    bit         m_blk = 1'b0;
    logic [2:0] m_mask = 3'd0;
    logic [1:0] m_el = 2'd0;
    logic [1:0] e_kind, e_itgt, e_stgt;
    bit         e_itake, e_ipend, e_stake, e_spend;

    always #4 clk = ~clk;

    intr_class_router dut (.*);

    function automatic logic [1:0] f_kind(bit ss, logic [1:0] g, bit ns, logic [1:0] el);
        bit cur_sec, g_sec;
        if (ss) return (g == 2'd2) ? 2'd1 : 2'd2;
        if (g == 2'd0 || g == 2'd3 || el == 2'd3) return 2'd2;
        cur_sec = !ns;
        g_sec   = (g == 2'd1);
        return (cur_sec == g_sec) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [1:0] f_tgt(bit rt, logic [1:0] el);
        if (rt) return 2'd3;
        return (el == 2'd2) ? 2'd2 : 2'd1;
    endfunction

    function automatic bit f_take(bit req, logic [1:0] tgt, logic [1:0] el, bit mb, bit blk);
        if (!req) return 1'b0;
        if (tgt > el) return 1'b1;
        if (tgt == el) return !mb && !blk;
        return 1'b0;
    endfunction

    // Compute expected outputs from current inputs and advance model state.
    task automatic model_step();
        bit rel, blk_eff, fq;
        logic [1:0] k, ti, ts;
        rel     = (|(m_mask & ~mask_i)) || (m_el != cur_el_i);
        blk_eff = m_blk && !rel;
        k  = f_kind(single_ss_i, int_grp_i, ns_state_i, cur_el_i);
        fq = (k == 2'd2);
        ti = f_tgt(fq ? route_fiq_i : route_irq_i, cur_el_i);
        ts = f_tgt(route_serr_i, cur_el_i);
        e_itake = f_take(int_req_i, ti, cur_el_i, fq ? mask_i[0] : mask_i[1], blk_eff);
        e_stake = f_take(serr_req_i, ts, cur_el_i, mask_i[2], blk_eff);
        e_ipend = int_req_i && !e_itake;
        e_spend = serr_req_i && !e_stake;
        e_kind  = int_req_i ? k : 2'd0;
        e_itgt  = int_req_i ? ti : 2'd0;
        e_stgt  = serr_req_i ? ts : 2'd0;
        if (e_itake || e_stake) m_blk = 1'b1;
        else if (rel)           m_blk = 1'b0;
        m_mask = mask_i;
        m_el   = cur_el_i;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply current inputs for one edge and compare all outputs.
    task automatic step(string tk, string tt, string tx, string ts);
        model_step();
        @(negedge clk);
        chk(tk, int_kind_o, e_kind);
        chk(tt, int_tgt_el_o, e_itgt);
        chk(tx, int_take_o, e_itake);
        chk(tx, int_pend_o, e_ipend);
        chk(ts, serr_tgt_el_o, e_stgt);
        chk(ts, serr_take_o, e_stake);
        chk(ts, serr_pend_o, e_spend);
    endtask

    task automatic set_in(bit ss, bit req, logic [1:0] g, bit ns, logic [1:0] el,
                          bit rf, bit ri, logic [2:0] m);
        single_ss_i = ss; int_req_i = req; int_grp_i = g; ns_state_i = ns;
        cur_el_i = el; route_fiq_i = rf; route_irq_i = ri; mask_i = m;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: outputs zero under reset with busy inputs
        set_in(1'b0, 1'b1, 2'd2, 1'b1, 2'd1, 1'b1, 1'b1, 3'd0);
        serr_req_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", int_kind_o, 0); chk("R1", int_take_o, 0); chk("R1", int_pend_o, 0);
        chk("R1", serr_take_o, 0); chk("R1", int_tgt_el_o, 0);
        rst_n = 1'b1;
        serr_req_i = 1'b0;

        // R12: idle path
        set_in(1'b0, 1'b0, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 3'd0);
        step("R12", "R12", "R12", "R12");
        // R2: single-state mode, all group codes
        for (int g = 0; g < 4; g++) begin
            set_in(1'b1, 1'b1, 2'(g), 1'b0, 2'd0, 1'b0, 1'b0, 3'd0);
            step("R2", "R5", "R6", "R12");
            chk("R2", int_kind_o, (g == 2) ? 1 : 2);
        end
        // R3: at top level a non-secure group 1 is FIQ; group 0 is FIQ below
        set_in(1'b0, 1'b1, 2'd2, 1'b1, 2'd3, 1'b1, 1'b1, 3'b111);
        step("R3", "R5", "R7", "R12");
        chk("R3", int_kind_o, 2);
        set_in(1'b0, 1'b1, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0, 3'b111);
        step("R3", "R5", "R6", "R12");
        chk("R6", int_take_o, 1);
        // R8: top level with low routing waits
        set_in(1'b0, 1'b1, 2'd2, 1'b1, 2'd3, 1'b0, 1'b0, 3'd0);
        step("R3", "R5", "R8", "R12");
        chk("R8", int_pend_o, 1);
        // R4 and R11: secure EL1, non-secure group 1 pending as FIQ, then state flips
        set_in(1'b0, 1'b1, 2'd2, 1'b0, 2'd1, 1'b1, 1'b0, 3'b000);
        step("R4", "R5", "R6", "R12");
        chk("R4", int_kind_o, 2);
        set_in(1'b0, 1'b1, 2'd2, 1'b1, 2'd1, 1'b1, 1'b0, 3'b010);
        step("R11", "R5", "R7", "R12");
        chk("R11", int_kind_o, 1);
        chk("R7", int_take_o, 0);
        // R10: same-level take, then block, then release by unmasking
        set_in(1'b0, 1'b1, 2'd2, 1'b1, 2'd1, 1'b0, 1'b0, 3'b000);
        step("R4", "R5", "R10", "R12");
        chk("R10", int_take_o, 1);
        step("R4", "R5", "R10", "R12");
        chk("R10", int_take_o, 0);
        mask_i = 3'b010;
        step("R4", "R5", "R10", "R12");
        mask_i = 3'b000;
        step("R4", "R5", "R10", "R12");
        chk("R10", int_take_o, 1);
        // R9: SError independent path
        set_in(1'b0, 1'b0, 2'd0, 1'b1, 2'd2, 1'b0, 1'b0, 3'b011);
        serr_req_i = 1'b1; route_serr_i = 1'b0;
        step("R12", "R12", "R12", "R9");
        chk("R9", serr_take_o, 1);
        route_serr_i = 1'b1; cur_el_i = 2'd3; mask_i = 3'b100;
        step("R12", "R12", "R12", "R9");
        chk("R9", serr_pend_o, 1);
        serr_req_i = 1'b0; route_serr_i = 1'b0;

        // Random stimulus
        for (int i = 0; i < 20000; i++) begin
            single_ss_i  = ($urandom % 4) == 0;
            int_req_i    = ($urandom % 5) != 0;
            int_grp_i    = 2'($urandom);
            ns_state_i   = 1'($urandom);
            cur_el_i     = (($urandom % 3) == 0) ? cur_el_i : 2'($urandom);
            route_fiq_i  = 1'($urandom);
            route_irq_i  = ($urandom % 4) == 0;
            route_serr_i = 1'($urandom);
            serr_req_i   = ($urandom % 3) == 0;
            mask_i       = {($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0};
            step("R3", "R5", "R7", "R9");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule